// File: doc/BRIEF.md
# I2S Audio Transmit Channel

This block is a single serial audio output channel. Software or a DMA engine writes sample words into an eight-entry buffer through a plain parallel write strobe. The channel takes words out of the buffer one at a time and shifts them out MSB first on a serial data line, framed by a bit clock and a word-select line in the usual I2S arrangement. Each word starts one bit clock after a word-select edge. Word select low carries the left channel and high carries the right.

The channel can generate the bit clock and word select itself (master). The bit-clock half period and the number of bit clocks per word-select half are both programmable. It can also follow a bit clock and word select driven from outside (slave). In that case it synchronises both lines into the system clock and acts on the edges of the bit clock. Samples are 8, 16 or 32 bits wide. In stereo framing each half frame takes a fresh word. In mono framing one word feeds both halves.

Two level comparators drive an interrupt request and a DMA request, each against its own programmable threshold. Mute silences the data line while framing goes on. Stop freezes the channel. A channel reset empties the buffer and clears all framing state. An empty buffer at a word boundary produces a silent word and sets a sticky underrun flag.

Top module: `i2s_tx_channel`

## Requirements
- R1: With `cfg_master`=1 the channel drives `sck_out` with a high and low time of `cfg_div`+1 system clocks each. It toggles `ws_out` only on a falling edge of `sck_out`, after every `cfg_half` bit-clock periods (0 counts as 1). `ws_out` is 1 after reset.
- R2: With `cfg_master`=0, `sck_out` and `ws_out` stay 0. Words are framed by `sck_in` and `ws_in`: data changes after a falling edge of `sck_in`, and word select is taken at its rising edges.
- R3: `cfg_width` picks the sample width: 0 means 8 bits, 1 means 16 bits, 2 or 3 means 32 bits. The sample is the low bits of the written word. It is sent MSB first, starting in the bit period that follows the first bit period carrying the new word-select level. Bit periods of the half beyond the width carry 0.
- R4: Word select 0 marks the left channel and 1 the right. In stereo (`cfg_mono`=0), consecutive buffer words go to left, then right.
- R5: In mono (`cfg_mono`=1), one buffer word is taken at each left start and the same sample is sent again in the following right half.
- R6: The buffer holds 8 words. A write while it holds 8 is dropped. `fifo_level` reports the number of words held.
- R7: `irq` is 1 exactly when `fifo_level` is below `cfg_irq_lvl`.
- R8: `dma_req` is 1 exactly when `fifo_level` is below `cfg_dma_lvl`.
- R9: While `cfg_mute`=1, `sd_out` is 0. Words are still taken from the buffer and word select keeps toggling.
- R10: While `cfg_stop`=1, no word is taken, `sd_out` is 0 and in master mode `sck_out`/`ws_out` hold still. Writes are still accepted.
- R11: `cfg_reset`=1 (like `rst`) empties the buffer, clears the underrun flag and returns the serialiser and clock state to their reset values.
- R12: If the buffer is empty when a word must be taken, that word is sent as zeros and `underrun` becomes 1. It stays 1 until a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master | input | 1 | 1: generate clocks, 0: follow external clocks |
| cfg_width | input | 2 | Sample width select (0: 8, 1: 16, 2/3: 32) |
| cfg_mono | input | 1 | 1: mono framing, 0: stereo |
| cfg_div | input | 8 | Bit-clock half period in system clocks, minus one |
| cfg_half | input | 7 | Bit clocks per word-select half |
| cfg_irq_lvl | input | 4 | Interrupt threshold on buffer level |
| cfg_dma_lvl | input | 4 | DMA request threshold on buffer level |
| cfg_mute | input | 1 | Force serial data to zero |
| cfg_stop | input | 1 | Halt transfers |
| cfg_reset | input | 1 | Channel reset |
| wr_en | input | 1 | Write strobe for the sample buffer |
| wr_data | input | 32 | Sample word to write |
| sck_in | input | 1 | External bit clock (slave) |
| ws_in | input | 1 | External word select (slave) |
| sck_out | output | 1 | Generated bit clock (master) |
| ws_out | output | 1 | Generated word select (master) |
| sd_out | output | 1 | Serial data |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |
| underrun | output | 1 | Sticky underrun flag |
| fifo_level | output | 4 | Words held in the buffer |

## Verification
The serial stream is decoded by a bench-side receiver that samples on rising bit-clock edges. It is run for every width in stereo and in mono, and for a half longer than the word. Distinct left and right values with upper bits that must be discarded separate width slicing, MSB ordering, channel order, left-word reuse in mono and zero padding. A slave run with an externally driven clock checks that the word start is tied to the external word select and not to internal counters. Directed runs cover buffer fill past capacity and the two thresholds, stop with a full buffer, mute with words queued, and an empty buffer at the first word.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

    localparam int SAMPLE_W = 32;

    typedef enum logic [1:0] {
        WLEN_8   = 2'd0,
        WLEN_16  = 2'd1,
        WLEN_32  = 2'd2,
        WLEN_32B = 2'd3
    } wlen_e;

    // One bit-clock falling edge, plus the word-select level of the bit period that just ended
    typedef struct packed {
        logic tick;
        logic ws_prev;
    } bit_evt_t;

    function automatic logic [5:0] wlen_bits(input wlen_e w);
        case (w)
            WLEN_8:  return 6'd8;
            WLEN_16: return 6'd16;
            default: return 6'd32;
        endcase
    endfunction

    // Moves the sample in the low bits up to the top, so bit SAMPLE_W-1 is the MSB
    function automatic logic [SAMPLE_W-1:0] left_justify(input logic [SAMPLE_W-1:0] d,
                                                         input wlen_e w);
        case (w)
            WLEN_8:  return {d[7:0], 24'h0};
            WLEN_16: return {d[15:0], 16'h0};
            default: return d;
        endcase
    endfunction

endpackage

// File: rtl/i2s_tx_fifo.sv
module i2s_tx_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         srst,
    input  logic                         wr_en,
    input  logic [W-1:0]                 wr_data,
    input  logic                         rd_en,
    output logic [W-1:0]                 rd_data,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          wr_ok, rd_ok;

    assign empty   = (level == '0);
    assign wr_ok   = wr_en && (level != LW'(DEPTH));
    assign rd_ok   = rd_en && !empty;
    assign rd_data = mem[rp];

    always_ff @(posedge clk) begin
        if (srst) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (wr_ok) begin
                mem[wp] <= wr_data;
                wp      <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            end
            if (rd_ok)
                rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            case ({wr_ok, rd_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (srst)
        level <= LW'(DEPTH));

    p_full_drop_r6: assert property (@(posedge clk) disable iff (srst)
        ($past(level) == LW'(DEPTH) && $past(wr_en) && !$past(rd_en) && !$past(srst))
        |-> level == LW'(DEPTH));

endmodule

// File: rtl/i2s_tx_clk.sv
module i2s_tx_clk
    import i2s_tx_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int HALF_W = 7
) (
    input  logic              clk,
    input  logic              srst,
    input  logic              master,
    input  logic              stop,
    input  logic [DIV_W-1:0]  div,
    input  logic [HALF_W-1:0] half,
    input  logic              sck_in,
    input  logic              ws_in,
    output bit_evt_t          evt,
    output logic              sck_o,
    output logic              ws_o
);
    // master state
    logic [DIV_W-1:0]  dcnt;
    logic [HALF_W-1:0] hcnt;
    logic              sck_q, ws_q;
    // slave state
    logic [2:0]        sck_s;
    logic [1:0]        ws_s;
    logic              ws_samp;
    logic              m_edge, m_fall, s_rise, s_fall, half_end;

    assign m_edge   = master && !stop && (dcnt == div);
    assign m_fall   = m_edge && sck_q;
    assign s_rise   = sck_s[1] && !sck_s[2];
    assign s_fall   = !sck_s[1] && sck_s[2];
    assign half_end = ({1'b0, hcnt} + 1'b1) >= {1'b0, half};

    always_ff @(posedge clk) begin
        if (srst) begin
            dcnt    <= '0;
            hcnt    <= '0;
            sck_q   <= 1'b0;
            ws_q    <= 1'b1;
            sck_s   <= '0;
            ws_s    <= 2'b11;
            ws_samp <= 1'b1;
        end else begin
            sck_s <= {sck_s[1:0], sck_in};
            ws_s  <= {ws_s[0], ws_in};
            if (s_rise)
                ws_samp <= ws_s[1];
            if (master && !stop) begin
                if (m_edge) begin
                    dcnt  <= '0;
                    sck_q <= ~sck_q;
                    if (sck_q) begin
                        if (half_end) begin
                            hcnt <= '0;
                            ws_q <= ~ws_q;
                        end else begin
                            hcnt <= hcnt + 1'b1;
                        end
                    end
                end else begin
                    dcnt <= dcnt + 1'b1;
                end
            end
        end
    end

    assign evt.tick    = master ? m_fall : s_fall;
    assign evt.ws_prev = master ? ws_q : ws_samp;
    assign sck_o       = master && sck_q;
    assign ws_o        = master && ws_q;

    p_ws_on_fall_r1: assert property (@(posedge clk) disable iff (srst)
        ($past(master) && !$past(srst) && !$stable(ws_q)) |-> $fell(sck_q));

    p_stop_freeze_r10: assert property (@(posedge clk) disable iff (srst)
        ($past(master) && $past(stop) && !$past(srst)) |-> ($stable(sck_q) && $stable(ws_q)));

endmodule

// File: rtl/i2s_tx_ser.sv
module i2s_tx_ser
    import i2s_tx_pkg::*;
(
    input  logic                clk,
    input  logic                srst,
    input  bit_evt_t            evt,
    input  wlen_e               wlen,
    input  logic                mono,
    input  logic                mute,
    input  logic                stop,
    input  logic                fifo_empty,
    input  logic [SAMPLE_W-1:0] fifo_data,
    output logic                pop,
    output logic                sd,
    output logic                underrun
);
    logic                ws_hist;
    logic [SAMPLE_W-1:0] shreg, held, word, lj;
    logic [5:0]          remain;
    logic                start, need_word;

    // a word starts one bit period after the word-select level changed
    assign start     = evt.tick && !stop && (evt.ws_prev != ws_hist);
    assign need_word = start && (!mono || !evt.ws_prev);
    assign pop       = need_word && !fifo_empty;
    assign word      = need_word ? (fifo_empty ? '0 : fifo_data) : held;
    assign lj        = left_justify(word, wlen);

    always_ff @(posedge clk) begin
        if (srst) begin
            ws_hist  <= 1'b1;
            shreg    <= '0;
            held     <= '0;
            remain   <= '0;
            sd       <= 1'b0;
            underrun <= 1'b0;
        end else begin
            if (evt.tick)
                ws_hist <= evt.ws_prev;
            if (stop) begin
                shreg  <= '0;
                remain <= '0;
                sd     <= 1'b0;
            end else if (evt.tick) begin
                if (start) begin
                    sd     <= lj[SAMPLE_W-1] && !mute;
                    shreg  <= lj << 1;
                    remain <= wlen_bits(wlen) - 6'd1;
                end else if (remain != '0) begin
                    sd     <= shreg[SAMPLE_W-1] && !mute;
                    shreg  <= shreg << 1;
                    remain <= remain - 6'd1;
                end else begin
                    sd <= 1'b0;
                end
            end else if (mute) begin
                sd <= 1'b0;
            end
            if (need_word)
                held <= word;
            if (need_word && fifo_empty)
                underrun <= 1'b1;
        end
    end

    p_mute_zero_r9: assert property (@(posedge clk) disable iff (srst)
        ($past(mute) && !$past(srst)) |-> !sd);

    p_underrun_sticky_r12: assert property (@(posedge clk) disable iff (srst)
        ($past(underrun) && !$past(srst)) |-> underrun);

    p_stop_silent_r10: assert property (@(posedge clk) disable iff (srst)
        ($past(stop) && !$past(srst)) |-> !sd);

endmodule

// File: rtl/i2s_tx_channel.sv
module i2s_tx_channel
    import i2s_tx_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DIV_W  = 8,
    parameter int HALF_W = 7,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_master,
    input  logic [1:0]          cfg_width,
    input  logic                cfg_mono,
    input  logic [DIV_W-1:0]    cfg_div,
    input  logic [HALF_W-1:0]   cfg_half,
    input  logic [LVL_W-1:0]    cfg_irq_lvl,
    input  logic [LVL_W-1:0]    cfg_dma_lvl,
    input  logic                cfg_mute,
    input  logic                cfg_stop,
    input  logic                cfg_reset,
    input  logic                wr_en,
    input  logic [SAMPLE_W-1:0] wr_data,
    input  logic                sck_in,
    input  logic                ws_in,
    output logic                sck_out,
    output logic                ws_out,
    output logic                sd_out,
    output logic                irq,
    output logic                dma_req,
    output logic                underrun,
    output logic [LVL_W-1:0]    fifo_level
);
    logic                srst;
    logic                pop, empty;
    logic [SAMPLE_W-1:0] head;
    bit_evt_t            evt;

    assign srst = rst || cfg_reset;

    i2s_tx_fifo #(.W(SAMPLE_W), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .srst    (srst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (pop),
        .rd_data (head),
        .level   (fifo_level),
        .empty   (empty)
    );

    i2s_tx_clk #(.DIV_W(DIV_W), .HALF_W(HALF_W)) u_clk (
        .clk    (clk),
        .srst   (srst),
        .master (cfg_master),
        .stop   (cfg_stop),
        .div    (cfg_div),
        .half   (cfg_half),
        .sck_in (sck_in),
        .ws_in  (ws_in),
        .evt    (evt),
        .sck_o  (sck_out),
        .ws_o   (ws_out)
    );

    i2s_tx_ser u_ser (
        .clk        (clk),
        .srst       (srst),
        .evt        (evt),
        .wlen       (wlen_e'(cfg_width)),
        .mono       (cfg_mono),
        .mute       (cfg_mute),
        .stop       (cfg_stop),
        .fifo_empty (empty),
        .fifo_data  (head),
        .pop        (pop),
        .sd         (sd_out),
        .underrun   (underrun)
    );

    assign irq     = fifo_level < cfg_irq_lvl;
    assign dma_req = fifo_level < cfg_dma_lvl;

    p_reset_clears_r11: assert property (@(posedge clk)
        $past(cfg_reset) |-> (fifo_level == '0 && !underrun));

endmodule

// File: tb/i2s_tx_channel_tb.sv
module i2s_tx_channel_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_master, cfg_mono, cfg_mute, cfg_stop, cfg_reset;
    logic [1:0]  cfg_width;
    logic [7:0]  cfg_div;
    logic [6:0]  cfg_half;
    logic [3:0]  cfg_irq_lvl, cfg_dma_lvl;
    logic        wr_en;
    logic [31:0] wr_data;
    logic        sck_in, ws_in;
    logic        sck_out, ws_out, sd_out, irq, dma_req, underrun;
    logic [3:0]  fifo_level;

    always #10 clk = ~clk;

    i2s_tx_channel dut_i (
        .clk(clk), .rst(rst), .cfg_master(cfg_master), .cfg_width(cfg_width),
        .cfg_mono(cfg_mono), .cfg_div(cfg_div), .cfg_half(cfg_half),
        .cfg_irq_lvl(cfg_irq_lvl), .cfg_dma_lvl(cfg_dma_lvl), .cfg_mute(cfg_mute),
        .cfg_stop(cfg_stop), .cfg_reset(cfg_reset), .wr_en(wr_en), .wr_data(wr_data),
        .sck_in(sck_in), .ws_in(ws_in), .sck_out(sck_out), .ws_out(ws_out),
        .sd_out(sd_out), .irq(irq), .dma_req(dma_req), .underrun(underrun),
        .fifo_level(fifo_level)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic ws_a [0:255];
    logic sd_a [0:255];
    int   ts_a [0:255];
    int   ncap;

    // vector: {width[1:0], mono, half[6:0], word0[31:0], word1[31:0]}
    localparam int NV = 6;
    localparam logic [73:0] VECS [NV] = '{
        {2'd1, 1'b0, 7'd16, 32'hFFFF_A5C3, 32'h0000_0F0F},
        {2'd0, 1'b0, 7'd8,  32'h1234_5681, 32'hFFFF_FF7E},
        {2'd2, 1'b0, 7'd32, 32'hDEAD_BEEF, 32'h1234_5678},
        {2'd1, 1'b1, 7'd16, 32'h0000_BEEF, 32'h0},
        {2'd0, 1'b1, 7'd8,  32'hABCD_EF3C, 32'h0},
        {2'd1, 1'b0, 7'd20, 32'h0000_9C31, 32'h0000_4E27}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic push(input logic [31:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic capture(input int n);
        int k = 0;
        int guard = 0;
        logic prev = sck_out;
        while (k < n && guard < 20000) begin
            @(negedge clk);
            guard++;
            if (sck_out && !prev) begin
                ws_a[k] = ws_out;
                sd_a[k] = sd_out;
                ts_a[k] = guard;
                k++;
            end
            prev = sck_out;
        end
        ncap = k;
    endtask

    function automatic int find_edge(input int from, input logic to_level);
        for (int k = from; k < ncap; k++)
            if (k > 0 && ws_a[k-1] == !to_level && ws_a[k] == to_level) return k;
        return -1;
    endfunction

    function automatic logic [31:0] grab(input int at, input int bits);
        logic [31:0] v = '0;
        for (int b = 0; b < bits; b++)
            v = {v[30:0], (at + b < ncap) ? sd_a[at + b] : 1'bx};
        return v;
    endfunction

    function automatic int width_bits(input logic [1:0] w);
        return (w == 2'd0) ? 8 : (w == 2'd1) ? 16 : 32;
    endfunction

    function automatic logic [31:0] low_bits(input logic [31:0] d, input int bits);
        return (bits == 32) ? d : (d & ((32'h1 << bits) - 1));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_master = 1'b1; cfg_mono = 1'b0; cfg_mute = 1'b0; cfg_stop = 1'b1;
        cfg_reset = 1'b0; cfg_width = 2'd1; cfg_div = 8'd1; cfg_half = 7'd16;
        cfg_irq_lvl = 4'd0; cfg_dma_lvl = 4'd0; wr_en = 1'b0; wr_data = '0;
        sck_in = 1'b0; ws_in = 1'b1;
        do_reset();

        // reset state (R11, R12, R1)
        check("R11 reset level", 32'(fifo_level), 32'd0);
        check("R12 reset underrun", 32'(underrun), 32'd0);
        check("R1 reset sck/ws/sd", {29'd0, sck_out, ws_out, sd_out}, 32'b010);

        // table of framing vectors (R1, R3, R4, R5)
        for (int v = 0; v < NV; v++) begin
            logic [1:0]  w    = VECS[v][73:72];
            logic        mono = VECS[v][71];
            int          half = int'(VECS[v][70:64]);
            logic [31:0] w0   = VECS[v][63:32];
            logic [31:0] w1   = VECS[v][31:0];
            int          bits = width_bits(w);
            int          il, ir;
            cfg_stop = 1'b1;
            do_reset();
            cfg_width = w; cfg_mono = mono; cfg_half = 7'(half); cfg_div = 8'd1;
            push(w0);
            if (!mono) push(w1);
            cfg_stop = 1'b0;
            capture(3 * half + 6);
            il = find_edge(1, 1'b0);
            ir = (il < 0) ? -1 : find_edge(il + 1, 1'b1);
            check($sformatf("R1 ws half period v%0d", v), 32'(ir - il), 32'(half));
            check($sformatf("R1 sck period v%0d", v), 32'(ts_a[2] - ts_a[1]), 32'd4);
            check($sformatf("R3 R4 left word v%0d", v), grab(il + 1, bits), low_bits(w0, bits));
            if (mono)
                check($sformatf("R5 mono right repeats left v%0d", v), grab(ir + 1, bits), low_bits(w0, bits));
            else
                check($sformatf("R4 right word v%0d", v), grab(ir + 1, bits), low_bits(w1, bits));
            if (half > bits)
                check($sformatf("R3 zero padding v%0d", v), grab(il + 1 + bits, half - bits), 32'd0);
        end

        // slave mode (R2)
        cfg_stop = 1'b0; cfg_master = 1'b0; cfg_width = 2'd0; cfg_mono = 1'b0;
        do_reset();
        push(32'h0000_00C5);
        push(32'h0000_003A);
        begin
            logic [31:0] lft = '0, rgt = '0;
            logic        quiet = 1'b1;
            for (int k = 0; k < 26; k++) begin
                sck_in = 1'b0;
                ws_in  = (k < 8) ? 1'b1 : (k < 16) ? 1'b0 : (k < 24) ? 1'b1 : 1'b0;
                repeat (7) @(negedge clk);
                if (sck_out || ws_out) quiet = 1'b0;
                if (k >= 9 && k <= 16)  lft = {lft[30:0], sd_out};
                if (k >= 17 && k <= 24) rgt = {rgt[30:0], sd_out};
                sck_in = 1'b1;
                repeat (8) @(negedge clk);
            end
            check("R2 slave left word", lft, 32'hC5);
            check("R2 slave right word", rgt, 32'h3A);
            check("R2 slave outputs quiet", 32'(quiet), 32'd1);
        end

        // buffer capacity and thresholds (R6, R7, R8), stop (R10), channel reset (R11)
        cfg_master = 1'b1; cfg_stop = 1'b1; cfg_irq_lvl = 4'd3; cfg_dma_lvl = 4'd6;
        do_reset();
        check("R7 irq at level 0", 32'(irq), 32'd1);
        check("R8 dma at level 0", 32'(dma_req), 32'd1);
        for (int i = 0; i < 3; i++) push(32'h100 + 32'(i));
        check("R7 irq off at level 3", 32'(irq), 32'd0);
        check("R8 dma on at level 3", 32'(dma_req), 32'd1);
        for (int i = 0; i < 3; i++) push(32'h200 + 32'(i));
        check("R8 dma off at level 6", 32'(dma_req), 32'd0);
        for (int i = 0; i < 4; i++) push(32'h300 + 32'(i));
        check("R6 level capped at 8", 32'(fifo_level), 32'd8);
        begin
            logic moved = 1'b0;
            for (int i = 0; i < 100; i++) begin
                @(negedge clk);
                if (sck_out || sd_out) moved = 1'b1;
            end
            check("R10 stop keeps buffer", 32'(fifo_level), 32'd8);
            check("R10 stop freezes clock/data", 32'(moved), 32'd0);
        end
        cfg_reset = 1'b1;
        @(negedge clk);
        cfg_reset = 1'b0;
        check("R11 channel reset empties", 32'(fifo_level), 32'd0);

        // mute (R9)
        cfg_stop = 1'b1; cfg_width = 2'd0; cfg_half = 7'd8; cfg_mono = 1'b0; cfg_mute = 1'b1;
        do_reset();
        push(32'hFF);
        push(32'hFF);
        cfg_stop = 1'b0;
        capture(30);
        begin
            logic any = 1'b0;
            for (int k = 0; k < ncap; k++) any |= sd_a[k];
            check("R9 mute zero data", 32'(any), 32'd0);
            check("R9 mute framing continues", 32'(find_edge(1, 1'b0) > 0), 32'd1);
            check("R9 mute still drains", 32'(fifo_level), 32'd0);
        end
        cfg_mute = 1'b0;

        // underrun (R12) then channel reset clears it (R11)
        cfg_stop = 1'b1;
        do_reset();
        cfg_stop = 1'b0;
        capture(30);
        begin
            int il = find_edge(1, 1'b0);
            check("R12 empty sends zeros", grab(il + 1, 8), 32'd0);
            check("R12 underrun set", 32'(underrun), 32'd1);
            repeat (20) @(negedge clk);
            check("R12 underrun sticky", 32'(underrun), 32'd1);
        end
        cfg_reset = 1'b1;
        @(negedge clk);
        cfg_reset = 1'b0;
        check("R11 reset clears underrun", 32'(underrun), 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule